// File: doc/BRIEF.md
# Six-Channel Packet Aggregation Scheduler

This block merges six independent byte streams into one outbound packet stream. Each channel writes bytes into a FIFO of its own. A polling engine visits the FIFOs one by one in a fixed cyclic order. When the FIFO it is visiting holds enough data, it builds one packet from that FIFO. The first beat of a packet is a routing header taken from a small per-channel register file, and the payload beats follow it.

A packet starts for one of two reasons. The FIFO may hold a full maximum payload. Or it may hold a partial payload while the channel's source has gone quiet, which means its `ch_active` status bit has stayed low for a programmable number of cycles. The incoming bursts carry no length field, so a quiet source is what marks the end of a burst.

Both data interfaces use valid/ready handshakes. On the input side, a byte is taken on a clock edge where `in_valid[i]` and `in_ready[i]` are both high. `in_ready[i]` falls only when the FIFO of that channel is full. On the output side, a beat moves on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the block holds every outbound signal steady. The sink may stall any beat for any number of cycles. Only one packet is in flight at a time.

Top module: `pkt_agg_top`

## Requirements
- R1: Each of the NCH channels has its own FIFO of FDEPTH bytes. A byte is stored on an edge where `in_valid[i]` and `in_ready[i]` are both high. `in_ready[i]` is low exactly when that FIFO holds FDEPTH bytes, and a byte offered while it is low is discarded.
- R2: A FIFO that holds MAXB or more bytes, when polled, starts a packet of exactly MAXB payload bytes. This happens whatever the state of `ch_active`.
- R3: A FIFO that holds from 1 to MAXB-1 bytes starts a packet carrying all of those bytes only when its channel is idle. While the channel is not idle, its partial data produces no output.
- R4: A channel is idle when `ch_active[i]` is low now and was also low at the last `idle_limit` consecutive rising edges.
- R5: The poller examines one channel per cycle in increasing index order and wraps from NCH-1 to 0. After a packet from channel c ends, polling resumes at channel c+1, so channels that are ready together are served in cyclic order.
- R6: The first beat of every packet has `out_sop`=1 and `out_bytes`=4. Its word holds the destination board in bits [31:24], the destination node in bits [23:16] and the payload byte count in bits [15:0]. The board and node values come from that channel's registers.
- R7: Payload bytes leave in arrival order, four per beat, with the earliest byte in bits [7:0]. Every payload beat except the last has `out_bytes`=4. The last beat has `out_eop`=1 and `out_bytes` from 1 to 4, and its unused upper byte lanes are zero.
- R8: While `out_valid` is high and `out_ready` is low, `out_data`, `out_sop`, `out_eop` and `out_bytes` keep their values into the next cycle. A new header never appears before the previous packet's end beat has been accepted.
- R9: The register address is {channel[CFG_AW-1:1], field[0]}, where field 0 is the destination board and field 1 is the destination node. `cfg_rdata` shows the addressed register in the same cycle. A channel index of NCH or more ignores writes and reads back 0. All registers reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NCH | Per-channel byte valid |
| in_data | input | NCH*8 | Per-channel byte; channel i uses bits [8i+7:8i] |
| in_ready | output | NCH | Per-channel FIFO not full |
| ch_active | input | NCH | Per-channel source-busy status |
| idle_limit | input | IDLE_W | Low-cycle count that makes a channel idle |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | CFG_AW | Register address {channel, field} |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| out_valid | output | 1 | Outbound beat valid |
| out_ready | input | 1 | Outbound sink ready |
| out_sop | output | 1 | Header beat marker |
| out_eop | output | 1 | Last payload beat marker |
| out_data | output | 32 | Header word or payload bytes |
| out_bytes | output | 3 | Valid byte count of the beat (1 to 4) |

## Verification
The bench builds the block with NCH=6, MAXB=16, FDEPTH=32 and IDLE_W=4, and drives `idle_limit` at 5. A 16-byte maximum payload lets short bursts reach the exact-maximum case and the one-byte-over case, and lets one burst split into a full packet and a partial remainder. A 32-byte FIFO can be filled to the point where `in_ready` drops while the outbound sink stalls. An idle limit of 5 gives a start window narrow enough to bound tightly: the header may first appear 6 cycles after `ch_active` falls and no later than 12 cycles after it.

// File: rtl/pkt_agg_pkg.sv
package pkt_agg_pkg;
  typedef enum logic [1:0] {ST_POLL, ST_HDR, ST_DATA} sched_state_t;

  typedef struct packed {
    logic [7:0] dst_board;
    logic [7:0] dst_node;
  } route_t;
endpackage

// File: rtl/agg_byte_fifo.sv
module agg_byte_fifo #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    din,
  output logic          full,
  output logic [CW-1:0] count,
  output logic [31:0]   peek,
  input  logic [2:0]    pop_n
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push_ok;

  assign full    = (count == CW'(DEPTH));
  assign push_ok = push && !full;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      rd_ptr <= rd_ptr + AW'(pop_n);
      count  <= count + CW'(push_ok) - CW'(pop_n);
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      peek[8*k +: 8] = mem[rd_ptr + AW'(k)];
    end
  end
endmodule

// File: rtl/agg_idle_mon.sv
module agg_idle_mon #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic [W-1:0] limit,
  output logic         idle
);
  logic [W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt <= '0;
    end else if (active) begin
      low_cnt <= '0;
    end else if (low_cnt != '1) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  assign idle = !active && (low_cnt >= limit);
endmodule

// File: rtl/agg_route_regs.sv
module agg_route_regs
  import pkt_agg_pkg::*;
#(
  parameter int NCH = 6,
  localparam int CHW = $clog2(NCH),
  localparam int AW = CHW + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [7:0]     cfg_wdata,
  output logic [7:0]     cfg_rdata,
  input  logic [CHW-1:0] sel,
  output route_t         route_sel
);
  route_t         regs [NCH];
  logic [CHW-1:0] a_ch;
  logic           a_fld;
  logic           a_ok;

  assign a_ch  = cfg_addr[AW-1:1];
  assign a_fld = cfg_addr[0];
  assign a_ok  = int'(a_ch) < NCH;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) regs[i] <= '0;
    end else if (cfg_we && a_ok) begin
      if (a_fld) regs[a_ch].dst_node  <= cfg_wdata;
      else       regs[a_ch].dst_board <= cfg_wdata;
    end
  end

  always_comb begin
    if (!a_ok)      cfg_rdata = '0;
    else if (a_fld) cfg_rdata = regs[a_ch].dst_node;
    else            cfg_rdata = regs[a_ch].dst_board;
  end

  assign route_sel = regs[sel];
endmodule

// File: rtl/agg_sched.sv
module agg_sched
  import pkt_agg_pkg::*;
#(
  parameter int NCH = 6,
  parameter int MAXB = 256,
  parameter int CW = 9,
  localparam int CHW = $clog2(NCH),
  localparam int LW = $clog2(MAXB + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCH*CW-1:0] fifo_count,
  input  logic [NCH-1:0]  ch_idle,
  input  route_t          route,
  input  logic [31:0]     head_bytes,
  output logic [CHW-1:0]  sel,
  output logic [2:0]      pop_n,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_sop,
  output logic            out_eop,
  output logic [31:0]     out_data,
  output logic [2:0]      out_bytes
);
  sched_state_t   state;
  logic [CHW-1:0] ptr;
  logic [LW-1:0]  remain, pkt_len, take;
  logic [CW-1:0]  cnt_p;
  logic           at_max, elig, last;
  logic [2:0]     beat_n;

  function automatic logic [CHW-1:0] next_ch(input logic [CHW-1:0] c);
    return (c == CHW'(NCH - 1)) ? '0 : c + 1'b1;
  endfunction

  assign cnt_p  = fifo_count[ptr*CW +: CW];
  assign at_max = cnt_p >= CW'(MAXB);
  assign elig   = at_max || (cnt_p != '0 && ch_idle[ptr]);
  assign take   = at_max ? LW'(MAXB) : LW'(cnt_p);
  assign last   = remain <= LW'(4);
  assign beat_n = last ? remain[2:0] : 3'd4;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_POLL;
      ptr     <= '0;
      sel     <= '0;
      remain  <= '0;
      pkt_len <= '0;
    end else begin
      case (state)
        ST_POLL: begin
          if (elig) begin
            sel     <= ptr;
            remain  <= take;
            pkt_len <= take;
            state   <= ST_HDR;
          end else begin
            ptr <= next_ch(ptr);
          end
        end
        ST_HDR: if (out_ready) state <= ST_DATA;
        ST_DATA: begin
          if (out_ready) begin
            remain <= remain - LW'(beat_n);
            if (last) begin
              state <= ST_POLL;
              ptr   <= next_ch(sel);
            end
          end
        end
        default: state <= ST_POLL;
      endcase
    end
  end

  assign out_valid = (state != ST_POLL);
  assign out_sop   = (state == ST_HDR);
  assign out_eop   = (state == ST_DATA) && last;
  assign out_bytes = (state == ST_DATA) ? beat_n : 3'd4;
  assign pop_n     = (state == ST_DATA && out_ready) ? beat_n : 3'd0;

  always_comb begin
    out_data = '0;
    if (state == ST_HDR) begin
      out_data = {route.dst_board, route.dst_node, 16'(pkt_len)};
    end else if (state == ST_DATA) begin
      for (int k = 0; k < 4; k++) begin
        out_data[8*k +: 8] = (3'(k) < beat_n) ? head_bytes[8*k +: 8] : 8'h00;
      end
    end
  end
endmodule

// File: rtl/pkt_agg_top.sv
module pkt_agg_top
  import pkt_agg_pkg::*;
#(
  parameter int NCH = 6,
  parameter int MAXB = 256,
  parameter int FDEPTH = 256,
  parameter int IDLE_W = 8,
  localparam int CFG_AW = $clog2(NCH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    in_valid,
  input  logic [NCH*8-1:0]  in_data,
  output logic [NCH-1:0]    in_ready,
  input  logic [NCH-1:0]    ch_active,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_sop,
  output logic              out_eop,
  output logic [31:0]       out_data,
  output logic [2:0]        out_bytes
);
  localparam int CW  = $clog2(FDEPTH + 1);
  localparam int CHW = $clog2(NCH);

  logic [NCH*CW-1:0] fifo_count;
  logic [NCH-1:0]    full, ch_idle;
  logic [31:0]       peek_all [NCH];
  logic [CHW-1:0]    sel;
  logic [2:0]        pop_n;
  route_t            route_sel;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [2:0] pop_i;
    assign pop_i       = (sel == CHW'(i)) ? pop_n : 3'd0;
    assign in_ready[i] = !full[i];

    agg_byte_fifo #(.DEPTH(FDEPTH)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[i]),
      .din   (in_data[i*8 +: 8]),
      .full  (full[i]),
      .count (fifo_count[i*CW +: CW]),
      .peek  (peek_all[i]),
      .pop_n (pop_i)
    );

    agg_idle_mon #(.W(IDLE_W)) u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (ch_active[i]),
      .limit  (idle_limit),
      .idle   (ch_idle[i])
    );
  end

  agg_route_regs #(.NCH(NCH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .sel       (sel),
    .route_sel (route_sel)
  );

  agg_sched #(.NCH(NCH), .MAXB(MAXB), .CW(CW)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .fifo_count (fifo_count),
    .ch_idle    (ch_idle),
    .route      (route_sel),
    .head_bytes (peek_all[sel]),
    .sel        (sel),
    .pop_n      (pop_n),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_sop    (out_sop),
    .out_eop    (out_eop),
    .out_data   (out_data),
    .out_bytes  (out_bytes)
  );
endmodule

// File: rtl/pkt_agg_chk.sv
module pkt_agg_chk #(
  parameter int MAXB = 256
) (
  input logic        clk,
  input logic        rst_n,
  input logic        out_valid,
  input logic        out_ready,
  input logic        out_sop,
  input logic        out_eop,
  input logic [31:0] out_data,
  input logic [2:0]  out_bytes
);
  logic        in_pkt;
  logic [15:0] hdr_len, byte_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt   <= 1'b0;
      hdr_len  <= '0;
      byte_acc <= '0;
    end else if (out_valid && out_ready) begin
      if (out_sop) begin
        in_pkt   <= 1'b1;
        hdr_len  <= out_data[15:0];
        byte_acc <= '0;
      end else begin
        byte_acc <= byte_acc + 16'(out_bytes);
        if (out_eop) in_pkt <= 1'b0;
      end
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop)
      && $stable(out_eop) && $stable(out_bytes));

  assert_one_pkt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> !in_pkt);

  assert_payload_after_hdr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_sop |-> in_pkt);

  assert_full_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eop |-> out_bytes == 3'd4);

  assert_last_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop |-> out_bytes != 3'd0 && out_bytes <= 3'd4 && !out_sop);

  assert_hdr_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sop |-> out_data[15:0] != 16'd0 && int'(out_data[15:0]) <= MAXB);

  assert_len_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eop |-> byte_acc + 16'(out_bytes) == hdr_len);
endmodule

bind pkt_agg_top pkt_agg_chk #(.MAXB(MAXB)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_data  (out_data),
  .out_bytes (out_bytes)
);

// File: tb/sim_pkt_agg_top.sv
`timescale 1ns/1ps
module sim_pkt_agg_top;
  localparam int NCH = 6;
  localparam int MAXB = 16;
  localparam int FDEPTH = 32;
  localparam int IDLE_W = 4;
  localparam int LIM = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NCH-1:0]    in_valid;
  logic [NCH*8-1:0]  in_data;
  logic [NCH-1:0]    in_ready;
  logic [NCH-1:0]    ch_active;
  logic [IDLE_W-1:0] idle_limit;
  logic              cfg_we;
  logic [3:0]        cfg_addr;
  logic [7:0]        cfg_wdata;
  logic [7:0]        cfg_rdata;
  logic              out_valid, out_ready, out_sop, out_eop;
  logic [31:0]       out_data;
  logic [2:0]        out_bytes;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [7:0] exp_board [NCH];
  logic [7:0] exp_node  [NCH];

  typedef struct packed {
    logic [2:0] ch;
    logic [7:0] n;
    logic [7:0] seed;
    logic       bp;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{3'd0, 8'd5,  8'h30, 1'b0},
    '{3'd3, 8'd16, 8'h50, 1'b0},
    '{3'd5, 8'd20, 8'h70, 1'b1},
    '{3'd1, 8'd1,  8'hE0, 1'b1},
    '{3'd2, 8'd31, 8'h90, 1'b0},
    '{3'd4, 8'd17, 8'h08, 1'b1}
  };

  pkt_agg_top #(.NCH(NCH), .MAXB(MAXB), .FDEPTH(FDEPTH), .IDLE_W(IDLE_W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .ch_active(ch_active), .idle_limit(idle_limit), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_sop(out_sop), .out_eop(out_eop), .out_data(out_data), .out_bytes(out_bytes)
  );

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic push_bytes(input int ch, input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid[ch] = 1'b1;
      in_data[ch*8 +: 8] = seed + 8'(i);
      while (!in_ready[ch]) @(negedge clk);
    end
    @(negedge clk);
    in_valid[ch] = 1'b0;
  endtask

  task automatic next_beat(input bit bp, output logic [31:0] d, output logic s, output logic e,
                           output logic [2:0] b, output bit to);
    bit stalled = 1'b0;
    logic [31:0] held = '0;
    to = 1'b1;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (stalled && out_valid) chk(out_data == held, "R8 beat held under stall", out_data, held);
      out_ready = bp ? !out_ready : 1'b1;
      #1;
      if (out_valid && out_ready) begin
        d = out_data; s = out_sop; e = out_eop; b = out_bytes; to = 1'b0;
        return;
      end
      stalled = out_valid;
      held = out_data;
    end
  endtask

  task automatic recv_pkt(input int ch, input int len, input logic [7:0] seed, input bit bp,
                          output int got_ch);
    logic [31:0] d; logic s, e; logic [2:0] b; bit to;
    logic [7:0] sd;
    int nb;
    logic [31:0] w;
    got_ch = ch;
    next_beat(bp, d, s, e, b, to);
    chk(!to, "R3 packet start (timeout)", {31'd0, to}, 32'd0);
    if (to) return;
    if (ch < 0) got_ch = int'(d[31:24]) - 16'h10;
    sd = (ch < 0) ? (8'hC0 + 8'(got_ch * 8)) : seed;
    if (got_ch < 0 || got_ch >= NCH) got_ch = 0;
    chk(s && b == 3'd4, "R6 header sop/bytes", {28'd0, s, b}, {28'd0, 1'b1, 3'd4});
    chk(d == {exp_board[got_ch], exp_node[got_ch], 16'(len)}, "R6 header word", d,
        {exp_board[got_ch], exp_node[got_ch], 16'(len)});
    for (int j = 0; j * 4 < len; j++) begin
      next_beat(bp, d, s, e, b, to);
      chk(!to, "R7 payload beat (timeout)", {31'd0, to}, 32'd0);
      if (to) return;
      nb = (len - j * 4 >= 4) ? 4 : len - j * 4;
      w = '0;
      for (int k = 0; k < nb; k++) w[8*k +: 8] = sd + 8'(j * 4 + k);
      chk(d == w, "R7 payload data", d, w);
      chk(b == 3'(nb) && e == (j * 4 + 4 >= len) && !s, "R7 beat flags",
          {27'd0, s, e, b}, {27'd0, 1'b0, (j * 4 + 4 >= len), 3'(nb)});
    end
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    int g, rem, off, l, n, pos;
    int got [3];
    int rr_list [3];
    bit quiet;
    rr_list = '{0, 2, 5};
    rst_n = 1'b0; in_valid = '0; in_data = '0; ch_active = '0; idle_limit = 4'(LIM);
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset out_valid", {31'd0, out_valid}, 32'd0);
    chk(in_ready == '1, "R1 reset in_ready", {26'd0, in_ready}, {26'd0, 6'h3F});
    chk(cfg_rdata == 8'h00, "R9 reset register", {24'd0, cfg_rdata}, 32'd0);
    rst_n = 1'b1;

    for (int c = 0; c < NCH; c++) begin
      exp_board[c] = 8'h10 + 8'(c);
      exp_node[c]  = 8'hA0 + 8'(c);
      cfg_write({3'(c), 1'b0}, exp_board[c]);
      cfg_write({3'(c), 1'b1}, exp_node[c]);
    end
    cfg_read({3'd3, 1'b1}, rd);
    chk(rd == 8'hA3, "R9 readback node ch3", {24'd0, rd}, 32'hA3);
    cfg_read({3'd5, 1'b0}, rd);
    chk(rd == 8'h15, "R9 readback board ch5", {24'd0, rd}, 32'h15);
    cfg_write({3'd6, 1'b0}, 8'hFF);
    cfg_write({3'd7, 1'b1}, 8'hEE);
    cfg_read({3'd6, 1'b0}, rd);
    chk(rd == 8'h00, "R9 out-of-range reads 0", {24'd0, rd}, 32'd0);
    cfg_read({3'd0, 1'b0}, rd);
    chk(rd == 8'h10, "R9 out-of-range write ignored", {24'd0, rd}, 32'h10);

    // Table walk: exact-max (R2), partial (R3), split bursts (R2, R3)
    for (int v = 0; v < 6; v++) begin
      @(negedge clk);
      ch_active[VEC[v].ch] = 1'b1;
      push_bytes(int'(VEC[v].ch), int'(VEC[v].n), VEC[v].seed);
      ch_active[VEC[v].ch] = 1'b0;
      rem = int'(VEC[v].n); off = 0;
      while (rem > 0) begin
        l = (rem >= MAXB) ? MAXB : rem;
        recv_pkt(int'(VEC[v].ch), l, VEC[v].seed + 8'(off), VEC[v].bp, g);
        rem -= l; off += l;
      end
    end

    // R3 / R4: partial data held while active, then idle window
    @(negedge clk);
    ch_active[4] = 1'b1;
    push_bytes(4, 2, 8'h44);
    quiet = 1'b1;
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      if (out_valid) quiet = 1'b0;
    end
    chk(quiet, "R3 no packet while active", {31'd0, !quiet}, 32'd0);
    ch_active[4] = 1'b0;
    n = 0;
    for (int t = 0; t < 60; t++) begin
      @(negedge clk);
      n++;
      if (out_valid) break;
    end
    chk(n >= LIM + 1 && n <= LIM + 1 + NCH, "R4 idle window", n, LIM + 1);
    recv_pkt(4, 2, 8'h44, 1'b0, g);

    // R1: fill a FIFO while the sink stalls
    @(negedge clk);
    ch_active[1] = 1'b1;
    push_bytes(1, FDEPTH, 8'h60);
    #1 chk(in_ready[1] == 1'b0, "R1 in_ready low when full", {31'd0, in_ready[1]}, 32'd0);
    in_valid[1] = 1'b1; in_data[15:8] = 8'hFE;
    @(negedge clk);
    in_valid[1] = 1'b0;
    ch_active[1] = 1'b0;
    recv_pkt(1, MAXB, 8'h60, 1'b0, g);
    recv_pkt(1, MAXB, 8'h70, 1'b1, g);
    quiet = 1'b1;
    for (int t = 0; t < 30; t++) begin
      @(negedge clk);
      if (out_valid) quiet = 1'b0;
    end
    chk(quiet, "R1 byte offered when full discarded", {31'd0, !quiet}, 32'd0);

    // R5: three channels ready together are served in cyclic order
    @(negedge clk);
    ch_active = 6'b100101;
    for (int i = 0; i < 3; i++) push_bytes(rr_list[i], 3, 8'hC0 + 8'(rr_list[i] * 8));
    @(negedge clk);
    ch_active = '0;
    for (int i = 0; i < 3; i++) recv_pkt(-1, 3, 8'h00, 1'b0, got[i]);
    pos = -1;
    for (int i = 0; i < 3; i++) if (rr_list[i] == got[0]) pos = i;
    chk(pos >= 0, "R5 first served is a loaded channel", got[0], rr_list[0]);
    if (pos < 0) pos = 0;
    chk(got[1] == rr_list[(pos + 1) % 3] && got[2] == rr_list[(pos + 2) % 3],
        "R5 cyclic service order", {got[1][15:0], got[2][15:0]},
        {16'(rr_list[(pos + 1) % 3]), 16'(rr_list[(pos + 2) % 3])});

    // R6: rewritten route appears in the next header
    cfg_write({3'd0, 1'b0}, 8'h77);
    cfg_write({3'd0, 1'b1}, 8'h55);
    exp_board[0] = 8'h77; exp_node[0] = 8'h55;
    @(negedge clk);
    ch_active[0] = 1'b1;
    push_bytes(0, 7, 8'h21);
    ch_active[0] = 1'b0;
    recv_pkt(0, 7, 8'h21, 1'b1, g);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule